// File: doc/BRIEF.md
# Paged Current-Offset Calibration Register

This block is one slice of the register file of a power-management bus target. For each of two output channels it holds a current-offset calibration value in the 16-bit linear number format. The format has a 5-bit exponent in bits 15:11 and an 11-bit two's-complement mantissa in bits 10:0. The exponent is fixed at -4, so one mantissa step is 62.5 mA. Only seven mantissa bits are stored: the sign in bit 10 and bits 5:0. Bits 9:6 always read back as copies of the sign. Any written value therefore folds into the range -4 A to +3.9375 A, and no range check is made.

A decoded write strobe, together with a 2-bit page code, selects channel 1, channel 2 or both channels at once. Channel 2 can be configured as a multiphase slave. In that state its own register cannot be written, and its read data shows channel 1. Any write aimed at channel 2 while it is a slave is refused. The refusal raises a one-cycle NACK and sets a sticky fault flag. The flag holds the alert request high until a clear-faults pulse arrives.

Top module: `paged_offset_cal`

## Requirements
- R1: Bits 15:11 of every read word are always 11100. Data written to bits 15:11 has no effect.
- R2: A write stores data bit 10 as the sign and data bits 5:0 as the low mantissa. Bits 9:6 of the read word equal bit 10. Written bits 9:6 are ignored, so 0xE401 reads back as 0xE7C1.
- R3: After reset, both channels read 0xE000 (0 A), and nack and alertReq are low.
- R4: A write with page code 00 updates channel 1 only.
- R5: A write with page code 01 while channel 2 is a master updates channel 2 only.
- R6: A write with page code 11 while channel 2 is a master updates both channels with the same value.
- R7: A write with page code 10 changes no channel and raises no NACK.
- R8: A write with page code 01 or 11 while ch2Slave is high leaves channel 2's own register unchanged. It raises nack for exactly the one cycle after the strobe. With page code 11, channel 1 is still updated.
- R9: A refused write sets a fault flag. alertReq is high from the cycle after the refused write until the cycle after a clrFault pulse. If a refused write and clrFault arrive in the same cycle, the flag stays set.
- R10: While ch2Slave is high, rdDataCh2 equals rdDataCh1. When ch2Slave goes low, rdDataCh2 again shows channel 2's own stored value.
- R11: rdData returns the channel 2 word (as shown on rdDataCh2) for page code 01, and the channel 1 word for every other page code. Stored values change on the clock edge at which wrStb is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrStb | input | 1 | Decoded write strobe for this register, one cycle |
| wrData | input | 16 | Write data word in linear format |
| pageSel | input | 2 | Page code: 00 channel 1, 01 channel 2, 11 both |
| ch2Slave | input | 1 | Channel 2 is configured as a multiphase slave |
| clrFault | input | 1 | Clear-faults pulse |
| rdDataCh1 | output | 16 | Channel 1 word |
| rdDataCh2 | output | 16 | Effective channel 2 word (channel 1 when slave) |
| rdData | output | 16 | Word selected by pageSel |
| nack | output | 1 | Refusal, high the cycle after a refused write |
| alertReq | output | 1 | Alert request, follows the sticky fault flag |

## Verification
On every cycle, the assertions check four things. A NACK only ever follows a refused write, and every refused write produces one. Channel 2's own register never changes while it is a slave. Channel 1 keeps its value when there is no write, and takes the low data bits after a page-00 write. The alert stays high until a clear arrives. Only the bench scenarios can show the exact aliasing of out-of-range words, the mirroring of channel 1 onto channel 2 in slave mode, the return of channel 2's own value when slave mode ends, the page-10 no-op, and the result when a clear and a refusal arrive together.

// File: rtl/ocal_pkg.sv
package ocal_pkg;
  localparam int EXP_W   = 5;
  localparam int MANT_W  = 11;
  localparam int WORD_W  = EXP_W + MANT_W;
  localparam int STORE_W = 7;
  localparam int LOW_W   = STORE_W - 1;
  localparam int EXT_W   = MANT_W - LOW_W;   // sign bit plus its copies
  localparam int NUM_CH  = 2;
  localparam logic [EXP_W-1:0] EXP_CODE = 5'b11100;

  localparam logic [1:0] PAGE_CH1  = 2'b00;
  localparam logic [1:0] PAGE_CH2  = 2'b01;
  localparam logic [1:0] PAGE_BOTH = 2'b11;

  typedef struct packed {
    logic [NUM_CH-1:0] wrCh;
    logic              reject;
  } ocal_strobe_t;

  function automatic logic [STORE_W-1:0] packStore(input logic [WORD_W-1:0] d);
    return {d[MANT_W-1], d[LOW_W-1:0]};
  endfunction

  function automatic logic [WORD_W-1:0] buildWord(input logic [STORE_W-1:0] s);
    return {EXP_CODE, {EXT_W{s[STORE_W-1]}}, s[LOW_W-1:0]};
  endfunction
endpackage

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
  import ocal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrStb,
  input  logic [1:0]   pageSel,
  input  logic         ch2Slave,
  input  logic         clrFault,
  output ocal_strobe_t strobe,
  output logic         nack,
  output logic         alertReq
);
  logic hitCh1, hitCh2, faultFlag;

  always_comb begin
    hitCh1 = (pageSel == PAGE_CH1) || (pageSel == PAGE_BOTH);
    hitCh2 = (pageSel == PAGE_CH2) || (pageSel == PAGE_BOTH);
    strobe.wrCh[0] = wrStb && hitCh1;
    strobe.wrCh[1] = wrStb && hitCh2 && !ch2Slave;
    strobe.reject  = wrStb && hitCh2 && ch2Slave;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nack      <= 1'b0;
      faultFlag <= 1'b0;
    end else begin
      nack <= strobe.reject;
      if (strobe.reject)  faultFlag <= 1'b1;
      else if (clrFault)  faultFlag <= 1'b0;
    end
  end

  assign alertReq = faultFlag;
endmodule

// File: rtl/ocal_dpath.sv
module ocal_dpath
  import ocal_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ocal_strobe_t      strobe,
  input  logic [WORD_W-1:0] wrData,
  input  logic [1:0]        pageSel,
  input  logic              ch2Slave,
  output logic [WORD_W-1:0] wordCh1,
  output logic [WORD_W-1:0] wordCh2Eff,
  output logic [WORD_W-1:0] wordCh2Own,
  output logic [WORD_W-1:0] wordSel
);
  logic [STORE_W-1:0] stored [NUM_CH];
  logic [STORE_W-1:0] wrVal;

  assign wrVal = packStore(wrData);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                stored[ch] <= '0;
      else if (strobe.wrCh[ch]) stored[ch] <= wrVal;
    end
  end

  always_comb begin
    wordCh1    = buildWord(stored[0]);
    wordCh2Own = buildWord(stored[1]);
    wordCh2Eff = ch2Slave ? wordCh1 : wordCh2Own;
    wordSel    = (pageSel == PAGE_CH2) ? wordCh2Eff : wordCh1;
  end
endmodule

// File: rtl/paged_offset_cal.sv
module paged_offset_cal
  import ocal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrStb,
  input  logic [15:0] wrData,
  input  logic [1:0]  pageSel,
  input  logic        ch2Slave,
  input  logic        clrFault,
  output logic [15:0] rdDataCh1,
  output logic [15:0] rdDataCh2,
  output logic [15:0] rdData,
  output logic        nack,
  output logic        alertReq
);
  ocal_strobe_t      strobe;
  logic [WORD_W-1:0] ch2Own;

  ocal_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrStb(wrStb), .pageSel(pageSel),
    .ch2Slave(ch2Slave), .clrFault(clrFault), .strobe(strobe),
    .nack(nack), .alertReq(alertReq)
  );

  ocal_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .pageSel(pageSel), .ch2Slave(ch2Slave), .wordCh1(rdDataCh1),
    .wordCh2Eff(rdDataCh2), .wordCh2Own(ch2Own), .wordSel(rdData)
  );
endmodule

// File: rtl/ocal_checker.sv
module ocal_checker (
  input logic        clk,
  input logic        rstN,
  input logic        wrStb,
  input logic [15:0] wrData,
  input logic [1:0]  pageSel,
  input logic        ch2Slave,
  input logic        clrFault,
  input logic [15:0] rdDataCh1,
  input logic [15:0] ch2Own,
  input logic        nack,
  input logic        alertReq
);
  p_nack_on_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && pageSel[0] && ch2Slave) |=> nack);

  p_nack_only_reject_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrStb && pageSel[0] && ch2Slave) |=> !nack);

  p_slave_locked_r8: assert property (@(posedge clk) disable iff (!rstN)
    ch2Slave |=> $stable(ch2Own));

  p_ch1_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !wrStb |=> $stable(rdDataCh1));

  p_ch1_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrStb && pageSel == 2'b00) |=> rdDataCh1[5:0] == $past(wrData[5:0]));

  p_alert_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    (alertReq && !clrFault) |=> alertReq);
endmodule

bind paged_offset_cal ocal_checker u_chk (
  .clk(clk), .rstN(rstN), .wrStb(wrStb), .wrData(wrData), .pageSel(pageSel),
  .ch2Slave(ch2Slave), .clrFault(clrFault), .rdDataCh1(rdDataCh1),
  .ch2Own(ch2Own), .nack(nack), .alertReq(alertReq)
);

// File: tb/paged_offset_cal_tb.sv
module paged_offset_cal_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrStb = 1'b0;
  logic [15:0] wrData = '0;
  logic [1:0]  pageSel = 2'b00;
  logic        ch2Slave = 1'b0;
  logic        clrFault = 1'b0;
  logic [15:0] rdDataCh1, rdDataCh2, rdData;
  logic        nack, alertReq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  paged_offset_cal u_dut (.*);

  function automatic logic [15:0] expWord(input logic [15:0] d);
    return {5'b11100, {5{d[10]}}, d[5:0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drives one write, returns at the falling edge after the sampling edge
  task automatic doWrite(input logic [1:0] pg, input logic [15:0] d);
    @(negedge clk);
    wrStb = 1'b1; pageSel = pg; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic t_reset;
    check("R3 ch1", rdDataCh1, 16'hE000);
    check("R3 ch2", rdDataCh2, 16'hE000);
    check("R3 nack", {15'd0, nack}, 16'd0);
    check("R3 alert", {15'd0, alertReq}, 16'd0);
  endtask

  task automatic t_page0;
    doWrite(2'b00, 16'h0015);
    check("R4 ch1", rdDataCh1, 16'hE015);
    check("R4 ch2 untouched", rdDataCh2, 16'hE000);
  endtask

  task automatic t_alias;
    doWrite(2'b00, 16'hE401);
    check("R2 alias neg", rdDataCh1, 16'hE7C1);
    doWrite(2'b00, 16'h03FF);
    check("R2 max pos", rdDataCh1, 16'hE03F);
    doWrite(2'b00, 16'h1F80);
    check("R1 exponent ignored", rdDataCh1, expWord(16'h1F80));
  endtask

  task automatic t_page1;
    doWrite(2'b01, 16'hFFC0);
    check("R5 ch2", rdDataCh2, 16'hE7C0);
    check("R5 ch1 untouched", rdDataCh1, 16'hE000);
    check("R5 nack", {15'd0, nack}, 16'd0);
    pageSel = 2'b01; #1;
    check("R11 page01 sel", rdData, 16'hE7C0);
  endtask

  task automatic t_both;
    doWrite(2'b11, 16'h0005);
    check("R6 ch1", rdDataCh1, 16'hE005);
    check("R6 ch2", rdDataCh2, 16'hE005);
  endtask

  task automatic t_page10;
    doWrite(2'b10, 16'h0011);
    check("R7 ch1", rdDataCh1, 16'hE005);
    check("R7 ch2", rdDataCh2, 16'hE005);
    check("R7 nack", {15'd0, nack}, 16'd0);
    check("R11 page10 sel", rdData, 16'hE005);
  endtask

  task automatic t_slave;
    doWrite(2'b00, 16'h0009);
    ch2Slave = 1'b1; #1;
    check("R10 mirror", rdDataCh2, 16'hE009);
    doWrite(2'b01, 16'h0022);
    check("R8 nack p01", {15'd0, nack}, 16'd1);
    check("R9 alert set", {15'd0, alertReq}, 16'd1);
    check("R8 ch1 untouched", rdDataCh1, 16'hE009);
    @(negedge clk);
    check("R8 nack one cycle", {15'd0, nack}, 16'd0);
    check("R9 alert held", {15'd0, alertReq}, 16'd1);
    doWrite(2'b11, 16'h0033);
    check("R8 nack p11", {15'd0, nack}, 16'd1);
    check("R8 ch1 updated", rdDataCh1, 16'hE033);
    check("R10 mirror after", rdDataCh2, 16'hE033);
    pageSel = 2'b11; #1;
    check("R11 page11 sel", rdData, 16'hE033);
  endtask

  task automatic t_clear;
    @(negedge clk); clrFault = 1'b1;
    @(negedge clk); clrFault = 1'b0;
    check("R9 cleared", {15'd0, alertReq}, 16'd0);
    // refused write together with clear: flag stays set
    @(negedge clk);
    wrStb = 1'b1; pageSel = 2'b01; wrData = 16'h0001; clrFault = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; clrFault = 1'b0;
    check("R9 set wins", {15'd0, alertReq}, 16'd1);
    ch2Slave = 1'b0; #1;
    check("R10 own value back", rdDataCh2, 16'hE005);
    check("R8 own not written", rdDataCh2, 16'hE005);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_page0();
    t_alias();
    doWrite(2'b00, 16'h0000);
    t_page1();
    t_both();
    t_page10();
    t_slave();
    t_clear();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule